// File: doc/BRIEF.md
# Soft Interrupt Pending Register

This unit holds the pending soft-interrupt word of one processor thread. Software reaches it through a small register-access interface with three addresses: one that replaces the whole word, one that ORs the written data into it, and one that clears the bits set in the written data. Timer-match inputs set two dedicated flag bits. All access is privileged. An unprivileged attempt is refused with a fault and the word is not touched.

From the stored word the unit derives the highest pending soft level, 1 to 15, or 0 when none is pending. It raises an interrupt request while that level exceeds the processor's current priority level. When an update lifts the pending level, it emits a one-cycle recheck pulse so the core looks at its interrupts again. Read data and fault flags come back one cycle after the access.

Top module: `sirq_unit`

## Requirements
- R1: After reset the stored word is zero and `rd_data`, `flt_priv`, `flt_ill`, `recheck`, `irq_req` and `pend_lvl` are all zero.
- R2: With `acc_priv` low, a read or write to address 0, 1 or 2 sets `flt_priv` in the next cycle, returns `rd_data` 0 and leaves bits 15:1 unchanged.
- R3: A privileged write to address 0 stores `acc_wdata`. Only the timer bits of R11 are OR-ed in.
- R4: A privileged write to address 1 stores the old word OR `acc_wdata`.
- R5: A privileged write to address 2 stores the old word AND NOT `acc_wdata`.
- R6: A privileged read of address 0 returns the stored word on `rd_data` in the next cycle, with no fault.
- R7: `pend_lvl` is the index of the highest set bit among bits 15:1 of the stored word, or 0 if none is set. Bit 0 is the tick-match flag and bit 16 is the stick-match flag; neither affects the level.
- R8: `recheck` is high for one cycle, the cycle after an update, exactly when the new pending level is strictly greater than the old one.
- R9: `irq_req` is high exactly while `pend_lvl` is greater than the `pil` input.
- R10: A privileged read of address 1 or 2, or any access to address 3, sets `flt_ill` in the next cycle, returns `rd_data` 0 and changes nothing.
- R11: `tick_hit` sets bit 0 and `stick_hit` sets bit 16 in the same update as any software access. A timer set wins over a simultaneous clear of the same bit.
- R12: When `acc_we` and `acc_re` are both high, only the write is performed, and `rd_data` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 2 | Register address: 0 direct, 1 set, 2 clear, 3 unmapped |
| acc_wdata | input | 17 | Write data |
| acc_we | input | 1 | Write enable |
| acc_re | input | 1 | Read enable |
| acc_priv | input | 1 | High when the access comes from privileged mode |
| tick_hit | input | 1 | Tick timer match, sets bit 0 |
| stick_hit | input | 1 | System-tick timer match, sets bit 16 |
| pil | input | 4 | Current processor interrupt level |
| rd_data | output | 17 | Read data, valid the cycle after a read |
| flt_priv | output | 1 | Privileged-opcode fault, the cycle after the access |
| flt_ill | output | 1 | Illegal-instruction fault, the cycle after the access |
| recheck | output | 1 | One-cycle pulse when the pending level rises |
| irq_req | output | 1 | Interrupt request: pending level above `pil` |
| pend_lvl | output | 4 | Highest pending soft level |

## Verification
The assertions check on every cycle that the two faults never coincide and that a fault always returns zero data. They check that the level bits survive unprivileged writes, that the OR alias and timer sets take effect, and that `recheck` matches a rise of `pend_lvl` in both directions. Other behaviour is shown only by the bench scenarios: the exact value stored by direct and clear writes, read-back, the precedence between write and read, illegal addresses, and the masking by `pil`. The bench compares these against its own model over directed and random access sequences.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_WDIR = 3'd1,
      OP_WSET = 3'd2,
      OP_WCLR = 3'd3,
      OP_READ = 3'd4
   } sirq_op_e;
endpackage

// File: rtl/sirq_access_dec.sv
module sirq_access_dec
   import sirq_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int A_DIR  = 0,
   parameter int A_SET  = 1,
   parameter int A_CLR  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   input  logic              priv,
   output sirq_op_e          op,
   output logic              flt_priv,
   output logic              flt_ill
);
   logic hit_dir, hit_set, hit_clr, mapped;

   assign hit_dir = (addr == ADDR_W'(A_DIR));
   assign hit_set = (addr == ADDR_W'(A_SET));
   assign hit_clr = (addr == ADDR_W'(A_CLR));
   assign mapped  = hit_dir | hit_set | hit_clr;

   always_comb begin
      op       = OP_IDLE;
      flt_priv = 1'b0;
      flt_ill  = 1'b0;
      if (we) begin
         if (!mapped)      flt_ill  = 1'b1;
         else if (!priv)   flt_priv = 1'b1;
         else if (hit_dir) op       = OP_WDIR;
         else if (hit_set) op       = OP_WSET;
         else              op       = OP_WCLR;
      end else if (re) begin
         if (!mapped)      flt_ill  = 1'b1;
         else if (!priv)   flt_priv = 1'b1;
         else if (hit_dir) op       = OP_READ;
         else              flt_ill  = 1'b1;
      end
   end
endmodule

// File: rtl/sirq_level_enc.sv
module sirq_level_enc #(
   parameter int LEVELS = 15,
   parameter int W      = LEVELS + 2,
   parameter int LVL_W  = $clog2(LEVELS + 1)
) (
   input  logic [W-1:0]     word,
   output logic [LVL_W-1:0] level
);
   logic [LEVELS+1:1] above;
   logic [LEVELS:1]   top;

   assign above[LEVELS+1] = 1'b0;

   for (genvar i = LEVELS; i >= 1; i--) begin : g_chain
      assign top[i]   = word[i] & ~above[i+1];
      assign above[i] = above[i+1] | word[i];
   end

   always_comb begin
      level = '0;
      for (int i = 1; i <= LEVELS; i++) begin
         level = level | (top[i] ? LVL_W'(i) : '0);
      end
   end
endmodule

// File: rtl/sirq_merge.sv
module sirq_merge
   import sirq_pkg::*;
#(
   parameter int W       = 17,
   parameter bit HW_WINS = 1'b1
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] wdata,
   input  sirq_op_e     op,
   input  logic         tick_hit,
   input  logic         stick_hit,
   output logic [W-1:0] nxt
);
   logic [W-1:0] hw;
   logic [W-1:0] base;
   logic [W-1:0] sw;

   always_comb begin
      hw        = '0;
      hw[0]     = tick_hit;
      hw[W-1]   = stick_hit;
   end

   if (HW_WINS) begin : g_hw_last
      assign base = cur;
      assign nxt  = sw | hw;
   end else begin : g_hw_first
      assign base = cur | hw;
      assign nxt  = sw;
   end

   always_comb begin
      unique case (op)
         OP_WDIR: sw = wdata;
         OP_WSET: sw = base | wdata;
         OP_WCLR: sw = base & ~wdata;
         default: sw = base;
      endcase
   end
endmodule

// File: rtl/sirq_unit.sv
module sirq_unit
   import sirq_pkg::*;
#(
   parameter int LEVELS  = 15,
   parameter int ADDR_W  = 2,
   parameter int A_DIR   = 0,
   parameter int A_SET   = 1,
   parameter int A_CLR   = 2,
   parameter bit HW_WINS = 1'b1,
   localparam int W      = LEVELS + 2,
   localparam int LVL_W  = $clog2(LEVELS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [W-1:0]      acc_wdata,
   input  logic              acc_we,
   input  logic              acc_re,
   input  logic              acc_priv,
   input  logic              tick_hit,
   input  logic              stick_hit,
   input  logic [LVL_W-1:0]  pil,
   output logic [W-1:0]      rd_data,
   output logic              flt_priv,
   output logic              flt_ill,
   output logic              recheck,
   output logic              irq_req,
   output logic [LVL_W-1:0]  pend_lvl
);
   if (LEVELS < 1) begin : g_bad_levels
      $error("sirq_unit: LEVELS must be at least 1");
   end
   if (A_DIR == A_SET || A_DIR == A_CLR || A_SET == A_CLR) begin : g_bad_map
      $error("sirq_unit: register addresses must be distinct");
   end
   if (A_DIR >= (1 << ADDR_W) || A_SET >= (1 << ADDR_W) || A_CLR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("sirq_unit: register address does not fit ADDR_W");
   end

   sirq_op_e         op;
   logic             dec_fp, dec_fi;
   logic [W-1:0]     soft_q, soft_d;
   logic [LVL_W-1:0] lvl_now, lvl_nxt;

   sirq_access_dec #(
      .ADDR_W(ADDR_W), .A_DIR(A_DIR), .A_SET(A_SET), .A_CLR(A_CLR)
   ) u_dec (
      .addr(acc_addr), .we(acc_we), .re(acc_re), .priv(acc_priv),
      .op(op), .flt_priv(dec_fp), .flt_ill(dec_fi)
   );

   sirq_merge #(.W(W), .HW_WINS(HW_WINS)) u_merge (
      .cur(soft_q), .wdata(acc_wdata), .op(op),
      .tick_hit(tick_hit), .stick_hit(stick_hit), .nxt(soft_d)
   );

   sirq_level_enc #(.LEVELS(LEVELS), .W(W), .LVL_W(LVL_W)) u_enc_now (
      .word(soft_q), .level(lvl_now)
   );

   sirq_level_enc #(.LEVELS(LEVELS), .W(W), .LVL_W(LVL_W)) u_enc_nxt (
      .word(soft_d), .level(lvl_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         soft_q   <= '0;
         rd_data  <= '0;
         flt_priv <= 1'b0;
         flt_ill  <= 1'b0;
         recheck  <= 1'b0;
      end else begin
         soft_q   <= soft_d;
         rd_data  <= (op == OP_READ) ? soft_q : '0;
         flt_priv <= dec_fp;
         flt_ill  <= dec_fi;
         recheck  <= (lvl_nxt > lvl_now);
      end
   end

   assign pend_lvl = lvl_now;
   assign irq_req  = (lvl_now > pil);
endmodule

// File: rtl/sirq_unit_chk.sv
module sirq_unit_chk #(
   parameter int LEVELS = 15,
   parameter int ADDR_W = 2,
   parameter int A_DIR  = 0,
   parameter int A_SET  = 1,
   parameter int A_CLR  = 2,
   localparam int W     = LEVELS + 2,
   localparam int LVL_W = $clog2(LEVELS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [W-1:0]      acc_wdata,
   input logic              acc_we,
   input logic              acc_priv,
   input logic              tick_hit,
   input logic              stick_hit,
   input logic [W-1:0]      rd_data,
   input logic              flt_priv,
   input logic              flt_ill,
   input logic              recheck,
   input logic              irq_req,
   input logic [LVL_W-1:0]  pend_lvl,
   input logic [W-1:0]      soft_q
);
   localparam logic [W-1:0] LVL_MASK = {1'b0, {LEVELS{1'b1}}, 1'b0};

   logic mapped;
   assign mapped = (acc_addr == ADDR_W'(A_DIR)) || (acc_addr == ADDR_W'(A_SET)) ||
                   (acc_addr == ADDR_W'(A_CLR));

   // R2 / R10: at most one fault, and a fault returns zero data
   assert_fault_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(flt_priv && flt_ill));
   assert_fault_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_priv || flt_ill) |-> (rd_data == '0));

   // R2: an unprivileged write leaves the level bits unchanged
   assert_nonpriv_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_we && !acc_priv && mapped) |=> ((soft_q & LVL_MASK) == ($past(soft_q) & LVL_MASK)));

   // R4: the set alias ORs the write data into the word
   assert_set_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_we && acc_priv && acc_addr == ADDR_W'(A_SET)) |=>
      ((soft_q & ($past(soft_q) | $past(acc_wdata))) == ($past(soft_q) | $past(acc_wdata))));

   // R11: timer matches always land
   assert_tick_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tick_hit |=> soft_q[0]);
   assert_stick_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stick_hit |=> soft_q[W-1]);

   // R8: recheck exactly when the level rose
   assert_recheck_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      recheck |-> (pend_lvl > $past(pend_lvl)));
   assert_rise_recheck_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_lvl > $past(pend_lvl)) |-> recheck);

   // R9: a request implies something is pending
   assert_req_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend_lvl != '0));
endmodule

bind sirq_unit sirq_unit_chk #(
   .LEVELS(LEVELS), .ADDR_W(ADDR_W), .A_DIR(A_DIR), .A_SET(A_SET), .A_CLR(A_CLR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
   .acc_we(acc_we), .acc_priv(acc_priv), .tick_hit(tick_hit), .stick_hit(stick_hit),
   .rd_data(rd_data), .flt_priv(flt_priv), .flt_ill(flt_ill), .recheck(recheck),
   .irq_req(irq_req), .pend_lvl(pend_lvl), .soft_q(soft_q)
);

// File: tb/sim_sirq_unit.sv
`timescale 1ns/1ps
module sim_sirq_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  acc_addr = '0;
   logic [16:0] acc_wdata = '0;
   logic        acc_we = 1'b0, acc_re = 1'b0, acc_priv = 1'b0;
   logic        tick_hit = 1'b0, stick_hit = 1'b0;
   logic [3:0]  pil = '0;
   logic [16:0] rd_data;
   logic        flt_priv, flt_ill, recheck, irq_req;
   logic [3:0]  pend_lvl;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [16:0] model = '0;

   always #10 clk = ~clk;

   sirq_unit u0 (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_we(acc_we), .acc_re(acc_re), .acc_priv(acc_priv),
      .tick_hit(tick_hit), .stick_hit(stick_hit), .pil(pil),
      .rd_data(rd_data), .flt_priv(flt_priv), .flt_ill(flt_ill),
      .recheck(recheck), .irq_req(irq_req), .pend_lvl(pend_lvl)
   );

   function automatic int lvl_of(logic [16:0] v);
      int r = 0;
      for (int i = 1; i <= 15; i++) if (v[i]) r = i;
      return r;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] a, input logic [16:0] d, input bit we,
                        input bit re, input bit pr, input bit th, input bit sh,
                        input logic [3:0] p, input string req);
      logic [16:0] old, nw, e_rd;
      bit e_fp, e_fi, mapped;
      @(negedge clk);
      acc_addr = a; acc_wdata = d; acc_we = we; acc_re = re; acc_priv = pr;
      tick_hit = th; stick_hit = sh; pil = p;
      old = model; nw = old; e_rd = '0; e_fp = 0; e_fi = 0;
      mapped = (a != 2'd3);
      if (we) begin
         if (!mapped) e_fi = 1;
         else if (!pr) e_fp = 1;
         else if (a == 2'd0) nw = d;
         else if (a == 2'd1) nw = old | d;
         else nw = old & ~d;
      end else if (re) begin
         if (!mapped) e_fi = 1;
         else if (!pr) e_fp = 1;
         else if (a == 2'd0) e_rd = old;
         else e_fi = 1;
      end
      if (th) nw[0] = 1'b1;
      if (sh) nw[16] = 1'b1;
      model = nw;
      @(negedge clk);
      acc_we = 0; acc_re = 0; tick_hit = 0; stick_hit = 0;
      check(req, "rd_data", int'(rd_data), int'(e_rd));
      check(req, "flt_priv", int'(flt_priv), int'(e_fp));
      check(req, "flt_ill", int'(flt_ill), int'(e_fi));
      check("R8", "recheck", int'(recheck), int'(lvl_of(nw) > lvl_of(old)));
      check("R7", "pend_lvl", int'(pend_lvl), lvl_of(nw));
      check("R9", "irq_req", int'(irq_req), int'(lvl_of(nw) > int'(p)));
   endtask

   task automatic read_back(string req);
      do_op(2'd0, '0, 0, 1, 1, 0, 0, pil, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seed = 32'h5a17;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", "rd_data", int'(rd_data), 0);
      check("R1", "flags", int'({flt_priv, flt_ill, recheck, irq_req}), 0);
      check("R1", "pend_lvl", int'(pend_lvl), 0);
      read_back("R1");
      // R3 direct write, R6 read-back
      do_op(2'd0, 17'h0_0024, 1, 0, 1, 0, 0, 4'd0, "R3");
      read_back("R6");
      // R4 set alias raises the level to 12
      do_op(2'd1, 17'h0_1000, 1, 0, 1, 0, 0, 4'd0, "R4");
      read_back("R4");
      // R9 masking by pil
      do_op(2'd0, '0, 0, 0, 1, 0, 0, 4'd12, "R9");
      do_op(2'd0, '0, 0, 0, 1, 0, 0, 4'd11, "R9");
      // R5 clear alias lowers the level, no recheck
      do_op(2'd2, 17'h0_1004, 1, 0, 1, 0, 0, 4'd0, "R5");
      read_back("R5");
      // R2 unprivileged write and read are refused
      do_op(2'd0, 17'h1_fffe, 1, 0, 0, 0, 0, 4'd0, "R2");
      do_op(2'd1, 17'h0_8000, 1, 0, 0, 0, 0, 4'd0, "R2");
      do_op(2'd0, '0, 0, 1, 0, 0, 0, 4'd0, "R2");
      read_back("R2");
      // R10 alias reads and address 3
      do_op(2'd1, '0, 0, 1, 1, 0, 0, 4'd0, "R10");
      do_op(2'd2, '0, 0, 1, 1, 0, 0, 4'd0, "R10");
      do_op(2'd3, 17'h0_ffff, 1, 0, 1, 0, 0, 4'd0, "R10");
      read_back("R10");
      // R11 timer sets win over a clear of the same bits
      do_op(2'd2, 17'h1_ffff, 1, 0, 1, 1, 1, 4'd0, "R11");
      read_back("R11");
      do_op(2'd0, 17'h0_0000, 1, 0, 1, 0, 1, 4'd0, "R11");
      read_back("R11");
      // R12 write and read together: only the write
      do_op(2'd0, 17'h0_4000, 1, 1, 1, 0, 0, 4'd3, "R12");
      read_back("R12");
      // R7 bits 0 and 16 alone give level 0
      do_op(2'd0, 17'h1_0001, 1, 0, 1, 0, 0, 4'd0, "R7");
      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [1:0]  a  = 2'($urandom_range(0, 3));
         logic [16:0] d  = 17'($urandom);
         bit          we = ($urandom_range(0, 2) != 0);
         bit          re = ($urandom_range(0, 2) == 0);
         bit          pr = ($urandom_range(0, 5) != 0);
         bit          th = ($urandom_range(0, 7) == 0);
         bit          sh = ($urandom_range(0, 7) == 0);
         logic [3:0]  p  = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 3) == 0) d = 17'(1) << $urandom_range(0, 16);
         do_op(a, d, we, re, pr, th, sh, p, "R3");
         if ((n % 7) == 0) read_back("R6");
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule